// File: doc/BRIEF.md
# Lane Tail Mask Generator and Predicate Fold

This block serves a vector unit in two ways. It turns a scalar lane count into a lane predicate, which is used to mask the unused tail of a vector for a partial-length operation. The predicate can be built for a 32-lane view, where each lane owns two adjacent predicate bits, or for a 64-lane view, where each lane owns one bit. Each view has a plain form and a clamping form. The 32-lane view also has forms that fill only the upper 16-lane half.

The same block also folds a 64-bit predicate into a single flag. An AND fold answers "are all lanes true". An OR fold answers "is any lane true". A fold covers either all 32 lane pairs or only the upper 16. In every fold, a lane pair is true when its low bit is set, and its high bit plays no part.

The function itself is combinational. A parameter adds one output register with a synchronous active-low reset, so that the result is presented one clock after the operands. Instruction decode happens outside the block, which receives an already decoded 4-bit operation code.

Top module: `lane_mask_fold`

## Requirements
- R1: With OUT_REG=1 the outputs are registered, and each result appears at the clock edge after its operands are sampled. A clock edge with rst_n low clears mask_o and flag_o to zero.
- R2: In op 0 (plain pair mask), lane l (bits 2l and 2l+1) is set exactly when l < count[4:0]. Examples: count 1 gives 0x3, count 8 gives 0xFFFF, count 16 gives 0xFFFFFFFF, and count 31 gives 0x3FFFFFFFFFFFFFFF.
- R3: In op 0, count bits above bit 4 are ignored. A count of 32 therefore gives an all-zero mask.
- R4: In op 1 (clamped pair mask), the count is treated as signed. A negative count gives zero. A count of 32 or more sets all 64 bits. Any other count behaves as in R2.
- R5: In op 2 (plain high-half mask), lane 16+l is set exactly when l < count[3:0], and bits 31:0 are zero.
- R6: In op 3 (clamped high-half mask), the count is signed and clamped to the range 0 to 16 before the R5 rule is applied. A count above 16 fills bits 63:32, and bits 31:0 stay zero.
- R7: In op 4 (plain bit mask), bit b is set exactly when b < count[5:0]. A count of 64 gives zero.
- R8: In op 5 (clamped bit mask), a negative count gives zero and a count above 63 is capped at 63. The capped result therefore has bits 62:0 set and bit 63 clear.
- R9: In op 8 (AND fold over all lanes), flag_o is 1 exactly when every even-numbered bit of pred_i is set. Odd-numbered bits have no effect, so 0x5555…5555 gives 1.
- R10: In op 9 (OR fold over all lanes), flag_o is 1 exactly when any even-numbered bit of pred_i is set. Examples: 0xAAAA…AAAA gives 0, 0x3 gives 1 and zero gives 0.
- R11: Ops 10 (AND) and 11 (OR) fold only the even bits 32 to 62, which are lanes 16 to 31. Bits 31:0 and the odd bits have no effect.
- R12: For a fold op, mask_o equals the flag in bit 0 with all other bits zero. For a mask op, flag_o is 0. The unassigned op codes 6, 7 and 12 to 15 give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Decoded operation code |
| count_i | input | CNT_W (32) | Scalar lane count, treated as signed by the clamping ops |
| pred_i | input | PRED_W (64) | Predicate that the fold ops reduce |
| mask_o | output | PRED_W (64) | Generated mask, or the fold flag in bit 0 |
| flag_o | output | 1 | Fold result; zero for the mask ops |

## Verification
For every mask op, the count is swept from -3 to 70. This range covers the zero and negative counts, each lane boundary, the wrap points at 32 and 64 where a plain op empties the mask, and the clamp points where a clamping op saturates instead. These sweeps tell a plain op apart from its clamping twin, and tell the pair view apart from the bit view.

The fold ops receive several predicate patterns:
- All ones and all zeros.
- Only even bits set, and only odd bits set. These show that odd bits are ignored.
- A single lane, to separate AND from OR.
- A single cleared lane in the low half and in the high half. This shows that the high-half folds ignore the lower lanes.
- An odd-only low half paired with a full high half.

The unassigned codes are also driven, to confirm that their outputs are all zero.

// File: rtl/lmf_pkg.sv
// Package for the tail mask / predicate fold block.
// It holds the operation codes, the internal view selector and the
// decode helpers. It assumes the 4-bit codes listed here are fixed.
package lmf_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_M32_PLAIN = 4'd0,
        OP_M32_SAT   = 4'd1,
        OP_M32_HI    = 4'd2,
        OP_M32_HISAT = 4'd3,
        OP_M64_PLAIN = 4'd4,
        OP_M64_SAT   = 4'd5,
        OP_AND_ALL   = 4'd8,
        OP_OR_ALL    = 4'd9,
        OP_AND_HI    = 4'd10,
        OP_OR_HI     = 4'd11
    } lmf_op_e;

    // Layout in which the mask generator writes its thermometer code
    typedef enum logic [1:0] {
        VIEW_OFF  = 2'd0,
        VIEW_PAIR = 2'd1,
        VIEW_HIGH = 2'd2,
        VIEW_BIT  = 2'd3
    } lmf_view_e;

    // Returns 1 when the code selects one of the six mask ops
    function automatic logic is_mask_op(input lmf_op_e op);
        return (op == OP_M32_PLAIN) || (op == OP_M32_SAT) ||
               (op == OP_M32_HI)    || (op == OP_M32_HISAT) ||
               (op == OP_M64_PLAIN) || (op == OP_M64_SAT);
    endfunction

    // Returns 1 when the code selects one of the four fold ops
    function automatic logic is_fold_op(input lmf_op_e op);
        return (op == OP_AND_ALL) || (op == OP_OR_ALL) ||
               (op == OP_AND_HI)  || (op == OP_OR_HI);
    endfunction

endpackage

// File: rtl/tail_mask_gen.sv
// Tail mask generator.
// It converts a lane count into a thermometer mask in one of three
// layouts: two bits per lane over all lanes, two bits per lane over the
// upper half only, or one bit per lane.
// Plain ops keep only the low count bits, so the count wraps.
// Clamping ops read the count as signed and limit it to a cap.
// Assumes PRED_W is a power of two and at least 8.
module tail_mask_gen
    import lmf_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRED_W = 64
) (
    input  lmf_op_e           op,
    input  logic [CNT_W-1:0]  count,
    output logic [PRED_W-1:0] mask
);
    localparam int LANES = PRED_W / 2;
    localparam int HALF  = LANES / 2;
    localparam int SH64  = $clog2(PRED_W);
    localparam int SH32  = $clog2(LANES);
    localparam int SHH   = $clog2(HALF);
    localparam int LIM_W = SH64 + 1;

    logic [LIM_W-1:0]  limit;
    lmf_view_e         view;
    logic [PRED_W-1:0] t_pair, t_high, t_bit;

    // Signed clamp of the count into the range [0, cap]
    function automatic logic [LIM_W-1:0] clamp(input logic [CNT_W-1:0] c,
                                               input logic [LIM_W-1:0] cap);
        if (c[CNT_W-1])
            return '0;
        else if (c > {{(CNT_W-LIM_W){1'b0}}, cap})
            return cap;
        else
            return c[LIM_W-1:0];
    endfunction

    // Pick the effective lane limit and the layout for the current op
    always_comb begin
        limit = '0;
        view  = VIEW_OFF;
        case (op)
            OP_M32_PLAIN: begin limit = LIM_W'(count[SH32-1:0]); view = VIEW_PAIR; end
            OP_M32_SAT:   begin limit = clamp(count, LIM_W'(LANES)); view = VIEW_PAIR; end
            OP_M32_HI:    begin limit = LIM_W'(count[SHH-1:0]);  view = VIEW_HIGH; end
            OP_M32_HISAT: begin limit = clamp(count, LIM_W'(HALF)); view = VIEW_HIGH; end
            OP_M64_PLAIN: begin limit = LIM_W'(count[SH64-1:0]); view = VIEW_BIT;  end
            OP_M64_SAT:   begin limit = clamp(count, LIM_W'(PRED_W-1)); view = VIEW_BIT; end
            default:      begin limit = '0; view = VIEW_OFF; end
        endcase
    end

    // One comparator per mask bit for each of the three layouts
    for (genvar b = 0; b < PRED_W; b++) begin : g_bit
        localparam int LANE = b / 2;
        assign t_pair[b] = (LIM_W'(LANE) < limit);
        assign t_bit[b]  = (LIM_W'(b) < limit);
        if (LANE >= HALF) begin : g_up
            assign t_high[b] = (LIM_W'(LANE - HALF) < limit);
        end else begin : g_low
            assign t_high[b] = 1'b0;
        end
    end

    // Route the layout chosen by the op to the output
    always_comb begin
        case (view)
            VIEW_PAIR: mask = t_pair;
            VIEW_HIGH: mask = t_high;
            VIEW_BIT:  mask = t_bit;
            default:   mask = '0;
        endcase
    end

endmodule

// File: rtl/pred_fold.sv
// Predicate fold.
// It reduces the low bit of every two-bit lane pair to one flag with AND
// or OR, over all lanes or over the upper half of the lanes only.
// The high bit of each pair is not read.
// Assumes PRED_W is even and at least 4.
module pred_fold
    import lmf_pkg::*;
#(
    parameter int PRED_W = 64
) (
    input  lmf_op_e           op,
    input  logic [PRED_W-1:0] pred,
    output logic              flag
);
    localparam int LANES = PRED_W / 2;
    localparam int HALF  = LANES / 2;

    logic [LANES-1:0] lane_on;

    // Take the low bit of each lane pair as that lane's truth value
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_on[l] = pred[2*l];
    end

    // Apply the reduction selected by the op
    always_comb begin
        case (op)
            OP_AND_ALL: flag = &lane_on;
            OP_OR_ALL:  flag = |lane_on;
            OP_AND_HI:  flag = &lane_on[LANES-1:HALF];
            OP_OR_HI:   flag = |lane_on[LANES-1:HALF];
            default:    flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/lane_mask_fold.sv
// Top level of the tail mask generator and predicate fold.
// It merges the two functions onto one result, with the fold flag
// placed in bit 0. It can register the outputs: a synchronous active-low
// reset clears the register, and with OUT_REG=0 the path is purely
// combinational.
// Assumes op_i is already decoded.
module lane_mask_fold
    import lmf_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PRED_W  = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [PRED_W-1:0] pred_i,
    output logic [PRED_W-1:0] mask_o,
    output logic              flag_o
);
    lmf_op_e           op;
    logic [PRED_W-1:0] gen_mask;
    logic              fold_flag;
    logic [PRED_W-1:0] res_mask;
    logic              res_flag;

    assign op = lmf_op_e'(op_i);

    tail_mask_gen #(.CNT_W(CNT_W), .PRED_W(PRED_W)) u_gen (
        .op    (op),
        .count (count_i),
        .mask  (gen_mask)
    );

    pred_fold #(.PRED_W(PRED_W)) u_fold (
        .op   (op),
        .pred (pred_i),
        .flag (fold_flag)
    );

    // Merge the mask and fold results into one output word
    always_comb begin
        if (is_fold_op(op)) begin
            res_mask = {{(PRED_W-1){1'b0}}, fold_flag};
            res_flag = fold_flag;
        end else if (is_mask_op(op)) begin
            res_mask = gen_mask;
            res_flag = 1'b0;
        end else begin
            res_mask = '0;
            res_flag = 1'b0;
        end
    end

    if (OUT_REG) begin : g_reg
        // Hold the result for one cycle; cleared by the synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_o <= '0;
                flag_o <= 1'b0;
            end else begin
                mask_o <= res_mask;
                flag_o <= res_flag;
            end
        end
    end else begin : g_comb
        assign mask_o = res_mask;
        assign flag_o = res_flag;
    end

endmodule

// File: rtl/lane_mask_fold_chk.sv
// Property checker for lane_mask_fold, attached with bind.
// It aligns the op and count with the output latency and then checks the
// shape of each result.
// Assumes rst_n is held low for at least one clock edge at start-up.
module lane_mask_fold_chk
    import lmf_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PRED_W  = 64,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic [CNT_W-1:0]  count_i,
    input logic [PRED_W-1:0] mask_o,
    input logic              flag_o
);
    localparam logic [PRED_W-1:0] EVEN = {(PRED_W/2){2'b01}};
    localparam int HALFB = PRED_W / 2;

    logic             past_ok;
    logic [OP_W-1:0]  op_s;
    logic [CNT_W-1:0] cnt_s;

    // Marks that at least one edge has passed out of reset
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    if (OUT_REG) begin : g_align
        logic [OP_W-1:0]  op_q;
        logic [CNT_W-1:0] cnt_q;
        // Delay the operands by the output register latency
        always_ff @(posedge clk) begin
            op_q  <= op_i;
            cnt_q <= count_i;
        end
        assign op_s  = op_q;
        assign cnt_s = cnt_q;
    end else begin : g_now
        assign op_s  = op_i;
        assign cnt_s = count_i;
    end

    a_r12_fold_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && is_fold_op(lmf_op_e'(op_s))) |->
            (mask_o[PRED_W-1:1] == '0 && mask_o[0] == flag_o));

    a_r12_mask_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && is_mask_op(lmf_op_e'(op_s))) |-> !flag_o);

    a_r2_pair_twin: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (op_s == OP_M32_PLAIN || op_s == OP_M32_SAT)) |->
            (((mask_o & EVEN) << 1) == (mask_o & ~EVEN)));

    a_r3_wrap_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_s == OP_M32_PLAIN && cnt_s[4:0] == 5'd0) |-> (mask_o == '0));

    a_r5_hi_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_s == OP_M32_HI) |-> (mask_o[HALFB-1:0] == '0));

    a_r6_hisat_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_s == OP_M32_HISAT) |-> (mask_o[HALFB-1:0] == '0));

    a_r7_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (op_s == OP_M64_PLAIN || op_s == OP_M64_SAT)) |->
            ((mask_o & (mask_o + 1'b1)) == '0));

    a_r8_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_s == OP_M64_SAT) |-> !mask_o[PRED_W-1]);

    a_r4_negative_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_s == OP_M32_SAT && cnt_s[CNT_W-1]) |-> (mask_o == '0));

endmodule

bind lane_mask_fold lane_mask_fold_chk #(
    .CNT_W(CNT_W), .PRED_W(PRED_W), .OUT_REG(OUT_REG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .count_i(count_i),
    .mask_o(mask_o), .flag_o(flag_o)
);

// File: tb/lane_mask_fold_tb.sv
`timescale 1ns/1ps
module lane_mask_fold_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [31:0] count_i = 32'd0;
    logic [63:0] pred_i = 64'd0;
    logic [63:0] mask_o;
    logic        flag_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] prev_m = 64'd0;
    logic        prev_f = 1'b0;

    always #2 clk = ~clk;

    lane_mask_fold u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .count_i(count_i),
        .pred_i(pred_i), .mask_o(mask_o), .flag_o(flag_o)
    );

    // Behavioural reference written from the requirement list
    function automatic void model(input int op, input logic [31:0] c,
                                  input logic [63:0] p,
                                  output logic [63:0] m, output logic f);
        longint sc = longint'($signed(c));
        int lim;
        m = 64'd0; f = 1'b0;
        case (op)
            0: begin lim = int'(c & 32'd31);
                     for (int l = 0; l < 32; l++) if (l < lim) m[2*l +: 2] = 2'b11; end
            1: begin lim = (sc < 0) ? 0 : ((sc > 32) ? 32 : int'(sc));
                     for (int l = 0; l < 32; l++) if (l < lim) m[2*l +: 2] = 2'b11; end
            2: begin lim = int'(c & 32'd15);
                     for (int l = 0; l < 16; l++) if (l < lim) m[32 + 2*l +: 2] = 2'b11; end
            3: begin lim = (sc < 0) ? 0 : ((sc > 16) ? 16 : int'(sc));
                     for (int l = 0; l < 16; l++) if (l < lim) m[32 + 2*l +: 2] = 2'b11; end
            4: begin lim = int'(c & 32'd63);
                     for (int b = 0; b < 64; b++) if (b < lim) m[b] = 1'b1; end
            5: begin lim = (sc < 0) ? 0 : ((sc > 63) ? 63 : int'(sc));
                     for (int b = 0; b < 64; b++) if (b < lim) m[b] = 1'b1; end
            8:  begin f = 1'b1; for (int l = 0;  l < 32; l++) f &= p[2*l]; m[0] = f; end
            9:  begin f = 1'b0; for (int l = 0;  l < 32; l++) f |= p[2*l]; m[0] = f; end
            10: begin f = 1'b1; for (int l = 16; l < 32; l++) f &= p[2*l]; m[0] = f; end
            11: begin f = 1'b0; for (int l = 16; l < 32; l++) f |= p[2*l]; m[0] = f; end
            default: begin m = 64'd0; f = 1'b0; end
        endcase
    endfunction

    // Requirement tag for each op code
    function automatic string tag_of(input int op);
        case (op)
            0: return "R2";  1: return "R4";  2: return "R5";  3: return "R6";
            4: return "R7";  5: return "R8";  8: return "R9";  9: return "R10";
            10, 11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] em, input logic ef);
        n_tests++;
        if (mask_o !== em || flag_o !== ef) begin
            n_fail++;
            $display("FAIL %s: mask=%h flag=%b expected mask=%h flag=%b",
                     tag, mask_o, flag_o, em, ef);
        end
    endtask

    // Drive one operand set, check that the old result holds until the edge
    // (R1), then check the new result after the edge
    task automatic run(input int op, input logic [31:0] c, input logic [63:0] p,
                       input string tag);
        logic [63:0] em; logic ef;
        @(negedge clk);
        op_i = 4'(op); count_i = c; pred_i = p;
        #1 check("R1 hold", prev_m, prev_f);
        model(op, c, p, em, ef);
        @(negedge clk);
        check(tag, em, ef);
        prev_m = em; prev_f = ef;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset clears the outputs even with a live op on the inputs
        op_i = 4'd1; count_i = 32'd40; pred_i = '1;
        repeat (3) @(negedge clk);
        check("R1 reset", 64'd0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        op_i = 4'd0; count_i = 32'd0;
        @(negedge clk);
        prev_m = 64'd0; prev_f = 1'b0;

        // R2 / R3 / R7 / R8: stated values and wrap points
        run(0, 32'd1,  '0, "R2 n=1");
        run(0, 32'd8,  '0, "R2 n=8");
        run(0, 32'd16, '0, "R2 n=16");
        run(0, 32'd31, '0, "R2 n=31");
        run(0, 32'd32, '0, "R3 n=32 wraps");
        run(0, 32'h0000_0123, '0, "R3 upper bits ignored");
        run(1, 32'h8000_0000, '0, "R4 most negative");
        run(1, 32'd1000, '0, "R4 over range");
        run(3, 32'd99, '0, "R6 clamp to 16");
        run(2, 32'd19, '0, "R5 uses low 4 bits");
        run(4, 32'd64, '0, "R7 n=64 wraps");
        run(5, 32'd64, '0, "R8 cap 63");
        run(5, 32'hFFFF_FFFF, '0, "R8 negative");

        // Sweep every mask op across the count boundaries
        for (int op = 0; op < 6; op++)
            for (int n = -3; n <= 70; n++)
                run(op, 32'(n), 64'hDEAD_BEEF_0F0F_F0F0, tag_of(op));

        // R9 R10 R11: fold patterns
        for (int op = 8; op < 12; op++) begin
            run(op, 32'd5, 64'hFFFF_FFFF_FFFF_FFFF, tag_of(op));
            run(op, 32'd5, 64'h0000_0000_0000_0000, tag_of(op));
            run(op, 32'd5, 64'h5555_5555_5555_5555, tag_of(op));
            run(op, 32'd5, 64'hAAAA_AAAA_AAAA_AAAA, tag_of(op));
            run(op, 32'd5, 64'h0000_0000_0000_0003, tag_of(op));
            run(op, 32'd5, 64'h0000_0001_0000_0000, tag_of(op));
            run(op, 32'd5, 64'hFFFF_FFFF_FFFF_FFFB, tag_of(op));
            run(op, 32'd5, 64'hFFFF_FFFB_FFFF_FFFF, tag_of(op));
            run(op, 32'd5, 64'h5555_5555_AAAA_AAAA, tag_of(op));
        end

        // R12: unassigned codes give zero outputs
        run(6,  32'd20, '1, "R12 code 6");
        run(7,  32'd20, '1, "R12 code 7");
        for (int op = 12; op < 16; op++) run(op, 32'd20, '1, "R12 spare code");
        run(9, 32'd0, '1, "R12 fold flag in bit 0");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule